// File: doc/BRIEF.md
# Random Weight Change Learning Engine

This block is a fully digital learning controller for a rectangular array of stored synapse weights. It does not compute a gradient. Each weight cell holds one direction bit. The direction bits of all cells form a single serial chain that takes one random bit per shift. A one-bit error-trend input is sampled on a valid strobe. Each strobe causes exactly one simultaneous update of every weight: a step up where the direction bit is 1, and a step down where it is 0.

After the update, the error trend decides what happens to the chain. If the error fell, the chain is left alone, so the same perturbation pattern is applied on the next strobe. If the error rose, the step already taken is kept and one fresh random bit is shifted in before the next update. A done pulse marks the end of each evaluation.

The up and down step sizes are separate inputs, because the two directions may need different magnitudes. Weights are signed values that saturate and never wrap. A synchronous reset clears the chain and loads every weight from a programmable initial value.

Top module: `rwc_learn_engine`

## Requirements
- R1: While `rst` is high at a clock edge, every direction bit becomes 0, every weight becomes `init_weight`, and `done_o` is low in the following cycle.
- R2: A `trend_valid` sampled high at edge k while the engine is idle causes one update of all weights at edge k+1. `done_o` is high for exactly the one cycle between edges k+1 and k+2.
- R3: At an update, a cell whose direction bit is 1 takes its weight plus the unsigned `step_up`, saturated at +127 (2**(WW-1)-1). Cell i = row*COLS+col uses `weights_o[i*WW +: WW]` (signed) and `dir_o[i]`.
- R4: At an update, a cell whose direction bit is 0 takes its weight minus the unsigned `step_dn`, saturated at -128 (-(2**(WW-1))).
- R5: When `err_rose` is 1 with the accepted strobe, the chain shifts once at edge k+2. The `rand_bit` sampled with the strobe enters cell 0, and cell i takes the old bit of cell i-1.
- R6: When `err_rose` is 0 with the accepted strobe, no direction bit changes, so the next update repeats the same pattern.
- R7: A `trend_valid` that is high while an evaluation is in progress (at edges k+1 and k+2) is ignored and produces no additional update or done pulse.
- R8: Weights change only at an update edge. Between updates all weights hold their values.
- R9: `step_up` and `step_dn` act independently. Each applies only to its own direction, with the value present at the update edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_weight | input | WW | Signed weight value loaded during reset |
| step_up | input | WW | Unsigned increment for cells with direction 1 |
| step_dn | input | WW | Unsigned decrement for cells with direction 0 |
| trend_valid | input | 1 | Strobe that starts one evaluation |
| err_rose | input | 1 | 1 when the error increased, 0 when it decreased |
| rand_bit | input | 1 | Random bit captured with the strobe |
| weights_o | output | ROWS*COLS*WW | All weights in parallel, cell i at bits i*WW upward |
| dir_o | output | ROWS*COLS | Direction bit of every cell |
| done_o | output | 1 | One-cycle pulse that ends each evaluation |

## Verification
The bench drives a 2-by-3 array through a long sweep of strobes with changing error trends, random bits and step sizes, and runs directed sequences that push weights into both saturation rails. Wrapping instead of clamping would send a weight near +127 to a large negative value, which the arithmetic model catches at once. The bench keeps `trend_valid` high across the busy cycles: a design that accepts it there would produce a second update and a second done pulse. It also compares the chain after every evaluation, so shifting on a falling error, or shifting in the wrong direction, shows up as a bit pattern that differs from the model.

// File: rtl/rwc_pkg.sv
package rwc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_UPD  = 2'd1,
    SEQ_SHF  = 2'd2
  } seq_state_t;

  // Clamp an integer into [lo, hi].
  function automatic int rwc_clamp(input int v, input int lo, input int hi);
    if (v > hi)      return hi;
    else if (v < lo) return lo;
    else             return v;
  endfunction

endpackage

// File: rtl/rwc_sequencer.sv
module rwc_sequencer (
  input  logic clk,
  input  logic rst,
  input  logic trend_valid,
  input  logic err_rose,
  input  logic rand_bit,
  output logic upd_evt,
  output logic shf_evt,
  output logic done_o,
  output logic shift_bit
);
  import rwc_pkg::*;

  seq_state_t state_q;
  logic       rose_q;
  logic       bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      rose_q  <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (trend_valid) begin
            state_q <= SEQ_UPD;
            rose_q  <= err_rose;
            bit_q   <= rand_bit;
          end
        end
        SEQ_UPD: state_q <= SEQ_SHF;
        SEQ_SHF: state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // Update phase and shift phase never overlap: they are different states.
  assign upd_evt   = (state_q == SEQ_UPD);
  assign done_o    = (state_q == SEQ_SHF);
  assign shf_evt   = done_o & rose_q;
  assign shift_bit = bit_q;

endmodule

// File: rtl/rwc_dir_chain.sv
module rwc_dir_chain #(
  parameter int N = 100
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [N-1:0] dir_o
);
  logic [N-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst)           chain_q <= '0;
    else if (shift_en) chain_q <= {chain_q[N-2:0], bit_in};
  end

  assign dir_o = chain_q;

endmodule

// File: rtl/rwc_weight_cell.sv
module rwc_weight_cell #(
  parameter int WW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [WW-1:0] init_w,
  input  logic        [WW-1:0] step_up,
  input  logic        [WW-1:0] step_dn,
  input  logic                 upd,
  input  logic                 dir,
  output logic signed [WW-1:0] w_o
);
  import rwc_pkg::*;

  localparam int WMAX = (2 ** (WW - 1)) - 1;
  localparam int WMIN = -(2 ** (WW - 1));

  function automatic logic signed [WW-1:0] next_weight(
    input logic signed [WW-1:0] cur,
    input logic                 up,
    input logic        [WW-1:0] inc,
    input logic        [WW-1:0] dec
  );
    int raw;
    raw = up ? (int'(cur) + int'(inc)) : (int'(cur) - int'(dec));
    return WW'(rwc_clamp(raw, WMIN, WMAX));
  endfunction

  logic signed [WW-1:0] w_q;

  always_ff @(posedge clk) begin
    if (rst)      w_q <= init_w;
    else if (upd) w_q <= next_weight(w_q, dir, step_up, step_dn);
  end

  assign w_o = w_q;

endmodule

// File: rtl/rwc_learn_engine.sv
module rwc_learn_engine #(
  parameter int ROWS = 10,
  parameter int COLS = 10,
  parameter int WW   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [WW-1:0]             init_weight,
  input  logic [WW-1:0]             step_up,
  input  logic [WW-1:0]             step_dn,
  input  logic                      trend_valid,
  input  logic                      err_rose,
  input  logic                      rand_bit,
  output logic [ROWS*COLS*WW-1:0]   weights_o,
  output logic [ROWS*COLS-1:0]      dir_o,
  output logic                      done_o
);
  localparam int N_CELLS = ROWS * COLS;

  logic               upd_evt;
  logic               shf_evt;
  logic               shift_bit;
  logic [N_CELLS-1:0] dir_w;

  rwc_sequencer seq_i (
    .clk        (clk),
    .rst        (rst),
    .trend_valid(trend_valid),
    .err_rose   (err_rose),
    .rand_bit   (rand_bit),
    .upd_evt    (upd_evt),
    .shf_evt    (shf_evt),
    .done_o     (done_o),
    .shift_bit  (shift_bit)
  );

  rwc_dir_chain #(.N(N_CELLS)) chain_i (
    .clk     (clk),
    .rst     (rst),
    .shift_en(shf_evt),
    .bit_in  (shift_bit),
    .dir_o   (dir_w)
  );

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    logic signed [WW-1:0] w_cell;
    rwc_weight_cell #(.WW(WW)) cell_i (
      .clk    (clk),
      .rst    (rst),
      .init_w (init_weight),
      .step_up(step_up),
      .step_dn(step_dn),
      .upd    (upd_evt),
      .dir    (dir_w[i]),
      .w_o    (w_cell)
    );
    assign weights_o[i*WW +: WW] = w_cell;
  end

  assign dir_o = dir_w;

endmodule

// File: rtl/rwc_learn_engine_chk.sv
module rwc_learn_engine_chk #(
  parameter int N  = 100,
  parameter int WW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          upd_evt,
  input logic          shf_evt,
  input logic          shift_bit,
  input logic          done_o,
  input logic [N*WW-1:0] weights_o,
  input logic [N-1:0]  dir_o
);

  assert_done_follows_update_R2: assert property (@(posedge clk) disable iff (rst)
    upd_evt |=> done_o);

  assert_done_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_no_update_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !upd_evt);

  assert_weights_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !upd_evt |=> $stable(weights_o));

  assert_chain_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !shf_evt |=> $stable(dir_o));

  assert_chain_shift_R5: assert property (@(posedge clk) disable iff (rst)
    shf_evt |=> (dir_o[N-1:1] == $past(dir_o[N-2:0])) && (dir_o[0] == $past(shift_bit)));

endmodule

bind rwc_learn_engine rwc_learn_engine_chk #(.N(N_CELLS), .WW(WW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .upd_evt  (upd_evt),
  .shf_evt  (shf_evt),
  .shift_bit(shift_bit),
  .done_o   (done_o),
  .weights_o(weights_o),
  .dir_o    (dir_o)
);

// File: tb/rwc_learn_engine_tb_top.sv
`timescale 1ns/1ps
module rwc_learn_engine_tb_top;
  localparam int ROWS = 2;
  localparam int COLS = 3;
  localparam int WW   = 8;
  localparam int N    = ROWS * COLS;

  logic            clk = 1'b0;
  logic            rst;
  logic [WW-1:0]   init_weight, step_up, step_dn;
  logic            trend_valid, err_rose, rand_bit;
  logic [N*WW-1:0] weights_o;
  logic [N-1:0]    dir_o;
  logic            done_o;

  int checks = 0;
  int failures = 0;
  int exp_w [N];
  bit exp_d [N];
  int seed = 32'h1234_5678;

  always #10 clk = ~clk;

  rwc_learn_engine #(.ROWS(ROWS), .COLS(COLS), .WW(WW)) dut_i (
    .clk(clk), .rst(rst), .init_weight(init_weight), .step_up(step_up),
    .step_dn(step_dn), .trend_valid(trend_valid), .err_rose(err_rose),
    .rand_bit(rand_bit), .weights_o(weights_o), .dir_o(dir_o), .done_o(done_o)
  );

  function automatic int wt(input int i);
    logic signed [WW-1:0] v;
    v = weights_o[i*WW +: WW];
    return int'(v);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_weights(input string tag);
    for (int i = 0; i < N; i++) chk(wt(i) == exp_w[i], tag, wt(i), exp_w[i]);
  endtask

  task automatic check_dirs(input string tag);
    for (int i = 0; i < N; i++) chk(dir_o[i] == exp_d[i], tag, int'(dir_o[i]), int'(exp_d[i]));
  endtask

  function automatic int nextrand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >>> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic do_reset(input int init_v);
    @(negedge clk);
    rst = 1'b1;
    init_weight = WW'(init_v);
    trend_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < N; i++) begin
      exp_w[i] = init_v;
      exp_d[i] = 1'b0;
    end
    check_weights("R1 reset weight");
    check_dirs("R1 reset chain");
    chk(done_o == 1'b0, "R1 done low after reset", int'(done_o), 0);
  endtask

  // One evaluation; hold keeps trend_valid high for that many edges (R7).
  task automatic step(input bit rose, input bit rbit, input int hold);
    int lo = -(2 ** (WW - 1));
    int hi = (2 ** (WW - 1)) - 1;
    trend_valid = 1'b1;
    err_rose = rose;
    rand_bit = rbit;
    @(posedge clk);
    @(negedge clk);
    if (hold <= 1) trend_valid = 1'b0;
    err_rose = ~rose;
    rand_bit = ~rbit;
    chk(done_o == 1'b0, "R2 done low before update", int'(done_o), 0);
    check_weights("R8 weights held before update edge");
    for (int i = 0; i < N; i++) begin
      if (exp_d[i]) exp_w[i] = (exp_w[i] + int'(step_up) > hi) ? hi : exp_w[i] + int'(step_up);
      else          exp_w[i] = (exp_w[i] - int'(step_dn) < lo) ? lo : exp_w[i] - int'(step_dn);
    end
    @(negedge clk);
    if (hold <= 2) trend_valid = 1'b0;
    chk(done_o == 1'b1, "R2 done pulse", int'(done_o), 1);
    for (int i = 0; i < N; i++)
      chk(wt(i) == exp_w[i], exp_d[i] ? "R3 up step" : "R4 down step", wt(i), exp_w[i]);
    if (rose) begin
      for (int i = N - 1; i > 0; i--) exp_d[i] = exp_d[i-1];
      exp_d[0] = rbit;
    end
    @(negedge clk);
    trend_valid = 1'b0;
    chk(done_o == 1'b0, "R2 done single cycle", int'(done_o), 0);
    check_dirs(rose ? "R5 chain shift" : "R6 chain kept");
    if (hold > 1) begin
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk(done_o == 1'b0, "R7 no extra done", int'(done_o), 0);
        check_weights("R7 no extra update");
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; trend_valid = 1'b0; err_rose = 1'b0; rand_bit = 1'b0;
    init_weight = '0; step_up = 8'd3; step_dn = 8'd5;

    // Basic patterns
    do_reset(10);
    step(1'b0, 1'b1, 1);
    step(1'b1, 1'b1, 1);
    step(1'b0, 1'b0, 1);
    step(1'b1, 1'b0, 1);
    step(1'b1, 1'b1, 1);

    // R9: asymmetric steps
    step_up = 8'd1; step_dn = 8'd9;
    step(1'b0, 1'b0, 1);
    step(1'b1, 1'b1, 1);

    // R7: strobe held through busy cycles
    step(1'b1, 1'b0, 3);

    // Upper saturation (R3)
    do_reset(120);
    step_up = 8'd5; step_dn = 8'd1;
    for (int k = 0; k < N; k++) step(1'b1, 1'b1, 1);
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1);

    // Lower saturation (R4)
    do_reset(-120);
    step_up = 8'd2; step_dn = 8'd7;
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1);

    // Full-range step values at both rails
    step_dn = 8'd255;
    step(1'b0, 1'b1, 1);
    step_up = 8'd255;
    for (int k = 0; k < N; k++) step(1'b1, 1'b1, 1);
    step(1'b0, 1'b0, 1);

    // Sweep with changing trends, bits and step sizes (R9)
    do_reset(0);
    for (int it = 0; it < 300; it++) begin
      int r;
      r = nextrand();
      step_up = WW'((it * 7) % 20);
      step_dn = WW'((it * 11) % 23);
      step(r[0], r[1], (r[5:3] == 3'd0) ? 3 : 1);
    end

    // R1: reset in mid-run
    do_reset(-3);
    step(1'b1, 1'b1, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule